// File: doc/BRIEF.md
# Serial EEPROM Word Access Master

This block lets a host read and write 16-bit words in a byte-organised serial EEPROM that uses four wires. The host presents a start word offset, a word count and a direction in one handshake. The block checks the request against the device size. It then wins access from a shared-access agent through a request/grant pair and polls the device until it is ready. After that it runs the read or write command sequence in SPI mode 0, with the serial clock divided down from the system clock.

Reads stream every requested word after a single opcode and address. Each word returns on `rdData` with a one-cycle `rdValid`. Writes pull one word per `wrTake` strobe from `wrData`. Before each write burst the block sends a write-enable command. It ends the burst at each device page boundary, waits a programmable settle time with access still held, and then acquires access again for the rest of the words. Every request ends with a one-cycle `done`. `err` pulses alongside `done` when the request failed.

Top module: `eeWordMaster`

## Requirements
- R1: A request is rejected when the offset is not below WORD_SIZE, when the count is zero, or when the count exceeds WORD_SIZE minus the offset. A rejected request pulses done and err together and never raises accReq.
- R2: accReq rises before any device traffic, and eeCsN is low only while accReq is high. If accGnt is not seen within GRANT_POLLS cycles, accReq drops and the request ends with err.
- R3: Before every command sequence the block sends status opcode 0x05 and reads 8 bits. It proceeds only when bit 0 is 0, pulsing eeCsN high between attempts. After READY_RETRIES busy replies it ends with err and drops accReq.
- R4: The address sent after the opcode is twice the word offset, MSB first, ADDR_BITS wide. When ADDR_BITS is 8 and the word offset is 128 or more, the opcode carries 0x08 as the ninth address bit.
- R5: Bits 7:0 of a host word sit at the even byte address and bits 15:8 at the odd byte address. Each word is sent and received as two bytes, lower address first.
- R6: A read of N words uses one read opcode 0x03 and address, then shifts in 16·N bits, with one rdValid per word.
- R7: Each write burst is write-enable 0x06, an eeCsN high pulse, then write opcode 0x02 with the address and the words. A burst ends after any word whose next byte address is a multiple of PAGE_BYTES.
- R8: SPI mode 0: eeSck idles low and is high only while eeCsN is low. eeMosi changes while eeSck is low, and it stays low while data is shifted in.
- R9: After each write burst, eeCsN goes high and accReq stays high for at least WRITE_WAIT cycles before it drops.
- R10: done is a single-cycle pulse per request, err is only high with done, and reqReady is low from acceptance until done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Host request strobe |
| reqReady | output | 1 | Block is idle and accepts a request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqOffset | input | 16 | Start word offset |
| reqCount | input | 16 | Number of words |
| wrData | input | 16 | Next word to write |
| wrTake | output | 1 | wrData is consumed this cycle |
| rdData | output | 16 | Word read |
| rdValid | output | 1 | rdData valid for one cycle |
| done | output | 1 | Request finished |
| err | output | 1 | Request failed (with done) |
| accReq | output | 1 | Access request to the shared agent |
| accGnt | input | 1 | Access grant |
| eeCsN | output | 1 | Device select, active low |
| eeSck | output | 1 | Serial clock |
| eeMosi | output | 1 | Serial data to device |
| eeMiso | input | 1 | Serial data from device |

## Verification
The bench uses a behavioural device model that decodes commands, holds a write-enable latch and reports busy for two status polls after each write. The corner cases are requests at the exact size limit, offsets above 127 where the ninth address bit moves into the opcode, and writes that cross page boundaries. With the address bit misplaced, the data comes from the wrong half of the device. A wrong page rule gives the wrong burst count or lost bytes. A swapped byte order shows up in the raw device bytes. A device that stays busy and a grant that never arrives must end with err and access released, not hang. A shortened settle window shows as accReq falling too early after a burst.

// File: rtl/eeWordPkg.sv
package eeWordPkg;
  localparam logic [7:0] OP_READ   = 8'h03;
  localparam logic [7:0] OP_WRITE  = 8'h02;
  localparam logic [7:0] OP_WREN   = 8'h06;
  localparam logic [7:0] OP_RDSR   = 8'h05;
  localparam logic [7:0] OP_HIADDR = 8'h08;

  // strobes from control to the bit engine
  typedef struct packed {
    logic        start;
    logic        rxMode;
    logic [4:0]  nBits;
    logic [15:0] txWord;
  } shStrb_t;

  function automatic logic [15:0] swapBytes(input logic [15:0] w);
    return {w[7:0], w[15:8]};
  endfunction
endpackage

// File: rtl/eeShifter.sv
module eeShifter
  import eeWordPkg::*;
#(
  parameter int CLK_DIV = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  shStrb_t     strb,
  input  logic        miso,
  output logic        sck,
  output logic        mosi,
  output logic        shDone,
  output logic [15:0] rxWord
);
  localparam int DW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

  logic          active, rxMode, phaseHigh;
  logic [DW-1:0] divCnt;
  logic [4:0]    bitsLeft;
  logic [15:0]   txSh;
  logic          halfEnd;

  assign halfEnd = (divCnt == DW'(CLK_DIV - 1));
  assign sck     = phaseHigh;
  assign mosi    = active & ~rxMode & txSh[15];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active <= 1'b0; rxMode <= 1'b0; phaseHigh <= 1'b0;
      divCnt <= '0; bitsLeft <= '0; txSh <= '0;
      rxWord <= '0; shDone <= 1'b0;
    end else begin
      shDone <= 1'b0;
      if (!active) begin
        if (strb.start) begin
          active    <= 1'b1;
          rxMode    <= strb.rxMode;
          phaseHigh <= 1'b0;
          divCnt    <= '0;
          bitsLeft  <= strb.nBits;
          txSh      <= strb.txWord << (5'd16 - strb.nBits);
        end
      end else if (halfEnd) begin
        divCnt <= '0;
        if (!phaseHigh) begin
          phaseHigh <= 1'b1;
        end else begin
          phaseHigh <= 1'b0;
          rxWord    <= {rxWord[14:0], miso};
          txSh      <= {txSh[14:0], 1'b0};
          bitsLeft  <= bitsLeft - 5'd1;
          if (bitsLeft == 5'd1) begin
            active <= 1'b0;
            shDone <= 1'b1;
          end
        end
      end else begin
        divCnt <= divCnt + DW'(1);
      end
    end
  end

  generate
    if (CLK_DIV > 1) begin : gHalf
      AST_HALF_PERIOD: assert property (@(posedge clk) disable iff (!rstN)
        $rose(sck) |=> sck); // R8
    end
  endgenerate
endmodule

// File: rtl/eeCtrl.sv
module eeCtrl
  import eeWordPkg::*;
#(
  parameter int WORD_SIZE     = 256,
  parameter int ADDR_BITS     = 8,
  parameter int PAGE_BYTES    = 16,
  parameter int CLK_DIV       = 2,
  parameter int GRANT_POLLS   = 32,
  parameter int READY_RETRIES = 8,
  parameter int WRITE_WAIT    = 200
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  output logic        reqReady,
  input  logic        reqWrite,
  input  logic [15:0] reqOffset,
  input  logic [15:0] reqCount,
  input  logic [15:0] wrData,
  output logic        wrTake,
  output logic [15:0] rdData,
  output logic        rdValid,
  output logic        done,
  output logic        err,
  output logic        accReq,
  input  logic        accGnt,
  output logic        csN,
  output shStrb_t     strb,
  input  logic        shDone,
  input  logic [15:0] rxWord
);
  localparam int          GAP_LEN   = 2 * CLK_DIV;
  localparam logic [16:0] PAGE_MASK = 17'(PAGE_BYTES / 2 - 1);

  typedef enum logic [3:0] {
    ST_IDLE, ST_ACQ, ST_POLLTX, ST_POLLRX, ST_GAP, ST_WREN,
    ST_OPC, ST_ADDR, ST_RXW, ST_TXW, ST_HOLD
  } state_t;

  state_t      state, gapNext;
  logic        launched, isWr, shiftState, badReq, a8, pageEnd;
  logic [31:0] cnt;
  logic [15:0] retry;
  logic [16:0] cur, left;

  assign reqReady = (state == ST_IDLE);
  assign badReq   = ({1'b0, reqOffset} >= 17'(WORD_SIZE)) || (reqCount == 16'd0) ||
                    ({1'b0, reqCount} > (17'(WORD_SIZE) - {1'b0, reqOffset}));
  assign a8       = (ADDR_BITS == 8) && cur[7];
  assign pageEnd  = (((cur + 17'd1) & PAGE_MASK) == 17'd0);

  always_comb begin
    shiftState = (state == ST_POLLTX) || (state == ST_POLLRX) || (state == ST_WREN) ||
                 (state == ST_OPC) || (state == ST_ADDR) || (state == ST_RXW) ||
                 (state == ST_TXW);
    strb        = '0;
    strb.start  = shiftState && !launched;
    strb.nBits  = 5'd8;
    wrTake      = 1'b0;
    case (state)
      ST_POLLTX: strb.txWord = {8'h00, OP_RDSR};
      ST_POLLRX: strb.rxMode = 1'b1;
      ST_WREN:   strb.txWord = {8'h00, OP_WREN};
      ST_OPC:    strb.txWord = {8'h00, (isWr ? OP_WRITE : OP_READ) | (a8 ? OP_HIADDR : 8'h00)};
      ST_ADDR: begin
        strb.txWord = {cur[14:0], 1'b0};
        strb.nBits  = 5'(ADDR_BITS);
      end
      ST_RXW: begin
        strb.rxMode = 1'b1;
        strb.nBits  = 5'd16;
      end
      ST_TXW: begin
        strb.txWord = swapBytes(wrData);
        strb.nBits  = 5'd16;
        wrTake      = strb.start;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE; gapNext <= ST_IDLE; launched <= 1'b0; isWr <= 1'b0;
      cnt <= '0; retry <= '0; cur <= '0; left <= '0;
      csN <= 1'b1; accReq <= 1'b0; done <= 1'b0; err <= 1'b0;
      rdValid <= 1'b0; rdData <= '0;
    end else begin
      done    <= 1'b0;
      err     <= 1'b0;
      rdValid <= 1'b0;
      if (strb.start) launched <= 1'b1;
      case (state)
        ST_IDLE: if (reqValid) begin
          if (badReq) begin
            done <= 1'b1; err <= 1'b1;
          end else begin
            cur <= {1'b0, reqOffset}; left <= {1'b0, reqCount};
            isWr <= reqWrite; cnt <= '0; state <= ST_ACQ;
          end
        end
        ST_ACQ: begin
          accReq <= 1'b1;
          if (accGnt && accReq) begin
            csN <= 1'b0; retry <= '0; state <= ST_POLLTX;
          end else if (cnt == 32'(GRANT_POLLS - 1)) begin
            accReq <= 1'b0; done <= 1'b1; err <= 1'b1; state <= ST_IDLE;
          end else cnt <= cnt + 32'd1;
        end
        ST_POLLTX: if (launched && shDone) begin
          launched <= 1'b0; state <= ST_POLLRX;
        end
        ST_POLLRX: if (launched && shDone) begin
          launched <= 1'b0; csN <= 1'b1; cnt <= '0;
          if (!rxWord[0]) begin
            gapNext <= isWr ? ST_WREN : ST_OPC; state <= ST_GAP;
          end else if (retry == 16'(READY_RETRIES - 1)) begin
            accReq <= 1'b0; done <= 1'b1; err <= 1'b1; state <= ST_IDLE;
          end else begin
            retry <= retry + 16'd1; gapNext <= ST_POLLTX; state <= ST_GAP;
          end
        end
        ST_GAP: if (cnt == 32'(GAP_LEN - 1)) begin
          csN <= 1'b0; state <= gapNext;
        end else cnt <= cnt + 32'd1;
        ST_WREN: if (launched && shDone) begin
          launched <= 1'b0; csN <= 1'b1; cnt <= '0; gapNext <= ST_OPC; state <= ST_GAP;
        end
        ST_OPC: if (launched && shDone) begin
          launched <= 1'b0; state <= ST_ADDR;
        end
        ST_ADDR: if (launched && shDone) begin
          launched <= 1'b0; state <= isWr ? ST_TXW : ST_RXW;
        end
        ST_RXW: if (launched && shDone) begin
          launched <= 1'b0; rdValid <= 1'b1; rdData <= swapBytes(rxWord);
          cur <= cur + 17'd1; left <= left - 17'd1;
          if (left == 17'd1) begin
            csN <= 1'b1; accReq <= 1'b0; done <= 1'b1; state <= ST_IDLE;
          end
        end
        ST_TXW: if (launched && shDone) begin
          launched <= 1'b0; cur <= cur + 17'd1; left <= left - 17'd1;
          if (left == 17'd1 || pageEnd) begin
            csN <= 1'b1; cnt <= '0; state <= ST_HOLD;
          end
        end
        ST_HOLD: if (cnt == 32'(WRITE_WAIT - 1)) begin
          accReq <= 1'b0; cnt <= '0;
          if (left == 17'd0) begin
            done <= 1'b1; state <= ST_IDLE;
          end else state <= ST_ACQ;
        end else cnt <= cnt + 32'd1;
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R10
  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rstN)
    err |-> done); // R10
  AST_BAD_REJECT: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && badReq) |=> (done && err && !accReq)); // R1
  AST_SELECT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    !csN |-> accReq); // R2
endmodule

// File: rtl/eeWordMaster.sv
module eeWordMaster
  import eeWordPkg::*;
#(
  parameter int WORD_SIZE     = 256,
  parameter int ADDR_BITS     = 8,
  parameter int PAGE_BYTES    = 16,
  parameter int CLK_DIV       = 2,
  parameter int GRANT_POLLS   = 32,
  parameter int READY_RETRIES = 8,
  parameter int WRITE_WAIT    = 200
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  output logic        reqReady,
  input  logic        reqWrite,
  input  logic [15:0] reqOffset,
  input  logic [15:0] reqCount,
  input  logic [15:0] wrData,
  output logic        wrTake,
  output logic [15:0] rdData,
  output logic        rdValid,
  output logic        done,
  output logic        err,
  output logic        accReq,
  input  logic        accGnt,
  output logic        eeCsN,
  output logic        eeSck,
  output logic        eeMosi,
  input  logic        eeMiso
);
  shStrb_t     strb;
  logic        shDone;
  logic [15:0] rxWord;

  eeCtrl #(
    .WORD_SIZE(WORD_SIZE), .ADDR_BITS(ADDR_BITS), .PAGE_BYTES(PAGE_BYTES),
    .CLK_DIV(CLK_DIV), .GRANT_POLLS(GRANT_POLLS), .READY_RETRIES(READY_RETRIES),
    .WRITE_WAIT(WRITE_WAIT)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqOffset(reqOffset), .reqCount(reqCount),
    .wrData(wrData), .wrTake(wrTake), .rdData(rdData), .rdValid(rdValid),
    .done(done), .err(err), .accReq(accReq), .accGnt(accGnt), .csN(eeCsN),
    .strb(strb), .shDone(shDone), .rxWord(rxWord)
  );

  eeShifter #(.CLK_DIV(CLK_DIV)) i_shift (
    .clk(clk), .rstN(rstN), .strb(strb), .miso(eeMiso),
    .sck(eeSck), .mosi(eeMosi), .shDone(shDone), .rxWord(rxWord)
  );

  AST_SCK_SELECTED: assert property (@(posedge clk) disable iff (!rstN)
    eeSck |-> !eeCsN); // R8
endmodule

// File: tb/test_eeWordMaster.sv
`timescale 1ns/1ps
module test_eeWordMaster;
  localparam int WS = 256, PB = 16, WW = 200, GP = 32;

  logic clk = 1'b0, rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [15:0] reqOffset = '0, reqCount = '0;
  logic [15:0] wrData, rdData;
  logic reqReady, wrTake, rdValid, done, err, accReq, accGnt;
  logic eeCsN, eeSck, eeMosi, eeMiso = 1'b0;

  always #2.5 clk = ~clk;

  eeWordMaster #(.WORD_SIZE(WS), .PAGE_BYTES(PB), .WRITE_WAIT(WW), .GRANT_POLLS(GP))
  i_eeWordMaster (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqOffset(reqOffset), .reqCount(reqCount),
    .wrData(wrData), .wrTake(wrTake), .rdData(rdData), .rdValid(rdValid),
    .done(done), .err(err), .accReq(accReq), .accGnt(accGnt),
    .eeCsN(eeCsN), .eeSck(eeSck), .eeMosi(eeMosi), .eeMiso(eeMiso)
  );

  // grant agent: three cycles of latency, drops at once with the request
  logic grantEn = 1'b1;
  logic [2:0] gDly = '0;
  always @(posedge clk) gDly <= {gDly[1:0], accReq & grantEn};
  assign accGnt = accReq & gDly[2];

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // device model: one process
  logic [7:0] mem [512];
  logic stuckBusy = 1'b0;
  int wrCmdCount = 0, wrenCount = 0, rdsrCount = 0, lastAddr = -1;
  int mosiViol = 0, wrEndCount = 0, lastWrEnd = 0;
  initial begin : model
    logic prevCs, prevSck, wel, sending, isRead, wroteData;
    logic [7:0] sr, outByte;
    int bitCnt, phase, addr, outBit, busyPolls;
    for (int i = 0; i < 512; i++) mem[i] = 8'((i * 37 + 5) & 255);
    prevCs = 1'b1; prevSck = 1'b0; wel = 0; sending = 0; isRead = 0; wroteData = 0;
    sr = 0; outByte = 0; bitCnt = 0; phase = 0; addr = 0; outBit = 0; busyPolls = 0;
    forever begin
      @(eeSck or eeCsN);
      if (eeCsN !== prevCs) begin
        if (!eeCsN) begin
          bitCnt = 0; phase = 0; sending = 0;
        end else begin
          sending = 0;
          if (wroteData) begin
            busyPolls = 2; wel = 0; wroteData = 0;
            lastWrEnd = cyc; wrEndCount++;
          end
        end
      end else if (!eeCsN && eeSck && !prevSck) begin
        if (sending && eeMosi) mosiViol++;
        sr = {sr[6:0], eeMosi}; bitCnt++;
        if (bitCnt == 8) begin
          bitCnt = 0;
          case (phase)
            0: begin
              if (sr == 8'h05) begin
                rdsrCount++;
                outByte = {7'd0, stuckBusy || busyPolls > 0};
                if (busyPolls > 0) busyPolls--;
                sending = 1; outBit = 0; phase = 3;
              end else if (sr == 8'h06) begin
                wel = 1; wrenCount++; phase = 3;
              end else if ((sr & 8'hF7) == 8'h03 || (sr & 8'hF7) == 8'h02) begin
                isRead = ((sr & 8'hF7) == 8'h03);
                addr = sr[3] ? 256 : 0;
                if (!isRead) wrCmdCount++;
                phase = 1;
              end else phase = 3;
            end
            1: begin
              addr = addr | int'(sr); lastAddr = addr;
              if (isRead) begin
                sending = 1; outByte = mem[addr]; outBit = 0; phase = 3;
              end else phase = 2;
            end
            2: begin
              if (wel) mem[addr] = sr;
              wroteData = 1; addr = (addr + 1) % 512;
            end
            default: ;
          endcase
        end
      end else if (!eeCsN && !eeSck && prevSck && sending) begin
        eeMiso = outByte[7 - outBit]; outBit++;
        if (outBit == 8) begin
          outBit = 0; addr = (addr + 1) % 512; outByte = mem[addr];
        end
      end
      prevCs = eeCsN; prevSck = eeSck;
    end
  end

  // monitors with their own counters
  int monChecks = 0, monFails = 0, selViol = 0, handledEnd = 0;
  logic prevAcc = 1'b0;
  always @(negedge clk) begin
    if (rstN && !eeCsN && !accReq) selViol++;
    if (prevAcc && !accReq && wrEndCount != handledEnd) begin
      handledEnd = wrEndCount; monChecks++;
      if (cyc - lastWrEnd < WW) begin
        monFails++;
        $display("FAIL R9 settle window actual=%0d expected>=%0d", cyc - lastWrEnd, WW);
      end
    end
    prevAcc = accReq;
  end

  int nChecks = 0, nFails = 0;
  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  logic [15:0] wrBuf [256];
  logic [15:0] rdBuf [256];
  logic [15:0] shadow [256];
  int wrIdx = 0;
  assign wrData = wrBuf[wrIdx[7:0]];

  logic gotErr, accSeen;
  int rdIdx;
  task automatic runReq(input bit wr, input int off, input int cnt, input bit good);
    bit takeSeen;
    takeSeen = 0; wrIdx = 0; rdIdx = 0; accSeen = 0;
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqValid = 1; reqWrite = wr; reqOffset = 16'(off); reqCount = 16'(cnt);
    @(negedge clk);
    reqValid = 0;
    if (good) chk(!reqReady, "R10", "ready while busy", 32'(reqReady), 0);
    forever begin
      if (takeSeen) wrIdx++;
      takeSeen = wrTake;
      if (rdValid) begin rdBuf[rdIdx[7:0]] = rdData; rdIdx++; end
      if (accReq) accSeen = 1;
      if (done) break;
      @(negedge clk);
    end
    gotErr = err;
    @(negedge clk);
    chk(!done, "R10", "done longer than one cycle", 32'(done), 0);
  endtask

  task automatic doRead(input int off, input int cnt, input string req);
    int bad;
    runReq(0, off, cnt, 1);
    chk(!gotErr, req, "read err", 32'(gotErr), 0);
    chk(rdIdx == cnt, "R6", "words returned", 32'(rdIdx), 32'(cnt));
    bad = 0;
    for (int i = 0; i < cnt; i++) if (rdBuf[i] !== shadow[off + i]) bad++;
    chk(bad == 0, req, "read data mismatches", 32'(bad), 0);
  endtask

  task automatic doWrite(input int off, input int cnt);
    for (int i = 0; i < cnt; i++) wrBuf[i] = 16'($urandom);
    runReq(1, off, cnt, 1);
    chk(!gotErr, "R7", "write err", 32'(gotErr), 0);
    chk(wrIdx == cnt, "R7", "words taken", 32'(wrIdx), 32'(cnt));
    for (int i = 0; i < cnt; i++) shadow[off + i] = wrBuf[i];
  endtask

  function automatic int burstsFor(input int off, input int cnt);
    int b = 1;
    for (int i = 0; i < cnt - 1; i++) if ((((off + i + 1) * 2) % PB) == 0) b++;
    return b;
  endfunction

  int seedDummy;
  initial begin : mainSeq
    int w0, e0, s0;
    seedDummy = $urandom(1234);
    for (int i = 0; i < 256; i++) shadow[i] = {8'((i * 74 + 42) & 255), 8'((i * 74 + 5) & 255)};
    repeat (3) @(negedge clk);
    chk(eeCsN === 1'b1 && eeSck === 1'b0, "R8", "idle lines in reset", {eeCsN, eeSck}, 2'b10);
    chk(accReq === 1'b0 && done === 1'b0, "R10", "outputs in reset", {accReq, done}, 0);
    rstN = 1;
    @(negedge clk);
    chk(reqReady === 1'b1, "R10", "ready after reset", 32'(reqReady), 1);

    // R1: rejects, including exact-limit neighbours
    runReq(0, 256, 1, 0);
    chk(gotErr && !accSeen, "R1", "offset at size", {gotErr, accSeen}, 2'b10);
    runReq(0, 10, 0, 0);
    chk(gotErr && !accSeen, "R1", "zero count", {gotErr, accSeen}, 2'b10);
    runReq(1, 250, 7, 0);
    chk(gotErr && !accSeen, "R1", "count past end", {gotErr, accSeen}, 2'b10);
    doRead(250, 6, "R1");

    // R4/R5: address doubling, ninth bit in opcode, byte order
    doRead(3, 1, "R5");
    chk(lastAddr == 6, "R4", "byte address low half", 32'(lastAddr), 6);
    doRead(200, 2, "R4");
    chk(lastAddr == 400, "R4", "ninth address bit", 32'(lastAddr), 400);
    doRead(120, 20, "R6");

    // R7: page-split write
    w0 = wrCmdCount; e0 = wrenCount; s0 = rdsrCount;
    doWrite(5, 12);
    chk(wrCmdCount - w0 == burstsFor(5, 12), "R7", "write bursts", 32'(wrCmdCount - w0), 32'(burstsFor(5, 12)));
    chk(wrenCount - e0 == 3, "R7", "write enables", 32'(wrenCount - e0), 3);
    chk(rdsrCount - s0 >= 5, "R3", "busy retries seen", 32'(rdsrCount - s0), 5);
    chk(mem[10] == wrBuf[0][7:0] && mem[11] == wrBuf[0][15:8], "R5", "device byte order",
        {mem[10], mem[11]}, {wrBuf[0][7:0], wrBuf[0][15:8]});
    doRead(5, 12, "R7");
    doWrite(130, 3);
    doRead(129, 5, "R4");

    // R3: device stays busy
    stuckBusy = 1;
    runReq(0, 0, 1, 1);
    chk(gotErr && !accReq && eeCsN, "R3", "stuck busy abort", {gotErr, accReq, eeCsN}, 3'b101);
    stuckBusy = 0;

    // R2: no grant
    grantEn = 0;
    runReq(0, 0, 1, 1);
    chk(gotErr && accSeen && !accReq, "R2", "grant timeout", {gotErr, accSeen, accReq}, 3'b110);
    grantEn = 1;

    // constrained random mix
    for (int t = 0; t < 24; t++) begin
      int off, maxc, cnt;
      off = int'($urandom % 256);
      maxc = (256 - off < 16) ? 256 - off : 16;
      cnt = 1 + int'($urandom % maxc);
      if ($urandom % 2) doWrite(off, cnt); else doRead(off, cnt, "R6");
    end
    doRead(0, 256, "R6");

    chk(mosiViol == 0, "R8", "mosi high while receiving", 32'(mosiViol), 0);
    chk(selViol == 0, "R2", "select without request", 32'(selViol), 0);
    chk(monChecks > 0, "R9", "settle windows observed", 32'(monChecks), 1);
    $display("End of test - %0d assertions evaluated, %0d failures",
             nChecks + monChecks, nFails + monFails);
    $finish;
  end

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures",
             nChecks + monChecks + 1, nFails + monFails + 1);
    $finish;
  end
endmodule